// File: doc/BRIEF.md
# Bit-Serial Maximum Finder

This block picks out which of several parallel bit streams carries the largest unsigned word. Every stream supplies one bit per clock. All streams run in lockstep and present their most significant bit first. The block does not compare whole words with a tree of magnitude comparators. Instead it keeps one candidate flag per stream. On each bit it drops any candidate that shows a 0 while some other surviving candidate shows a 1. The test behind this is a single OR-reduction across all streams.

A word starts with a one-cycle start strobe, which makes every stream a candidate again. The word bits then follow, each one qualified by a valid signal; gaps are allowed. When the last bit has been absorbed, the block raises done for one cycle. The surviving flags then mark every stream that holds the maximum, and the index output names the lowest-numbered survivor. Flags and index stay put until the next start. With 16 streams of 8-bit words, a new result is ready every 9 clocks: one start cycle plus 8 bits.

Top module: `bitser_max_finder`

## Requirements
- R1: While reset is active and after it is released, the candidate flags are all 0, done is 0 and the index is 0 until the first start.
- R2: A clock edge with start high sets every candidate flag to 1 and holds done at 0 in the following cycle.
- R3: On an edge with bit_valid high during a word, a flagged stream whose bit is 1 stays flagged. A flagged stream whose bit is 0 is cleared if and only if at least one flagged stream has a 1. A cleared flag never returns without a start.
- R4: An edge with bit_valid low leaves the flags and the bit count unchanged.
- R5: done is high for exactly one cycle. That cycle follows the edge that absorbs the WORD_BITS-th valid bit after a start.
- R6: While done is high, the flags are 1 exactly for the streams whose word equals the largest word of that batch, so at least one flag is set.
- R7: The index equals the position of the lowest-numbered set flag, and 0 when no flag is set.
- R8: After done, further valid bits are ignored: flags and index hold, and done stays 0, until the next start.
- R9: A start during a word abandons that word and restarts it. When start and bit_valid are both high on the same edge, start wins and the bits of that cycle are not used.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begins a new word; sets every candidate flag |
| bit_valid | input | 1 | Qualifies stream_bits for this cycle |
| stream_bits | input | NUM_STREAMS | Current bit of each stream, bit i from stream i, MSB of each word first |
| cand_flags | output | NUM_STREAMS | Candidate flag per stream |
| max_index | output | $clog2(NUM_STREAMS) | Lowest-numbered set candidate flag |
| done | output | 1 | One-cycle pulse after the last bit of a word |

## Verification
The assertions check properties that hold on every cycle. A start always yields a full flag set. Outside a start, flags can only fall, and a non-empty set never empties. Flags hold when no bit is valid and after completion. done never lasts two cycles, and at done the index points at the lowest set flag. Other behaviours depend on the word contents and need the bench's scenarios. These are whether the survivors are exactly the streams that hold the maximum, how ties resolve, the exact cycle of done, and the restart on a mid-word start.

// File: rtl/bsm_pkg.sv
package bsm_pkg;
  localparam int unsigned DEF_STREAMS = 16;
  localparam int unsigned DEF_WORD_BITS = 8;
endpackage

// File: rtl/bsm_reset_sync.sv
module bsm_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;
endmodule

// File: rtl/bsm_bit_counter.sv
module bsm_bit_counter #(
  parameter int unsigned WORD_BITS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic bit_valid,
  output logic take_bit,
  output logic done
);
  localparam int unsigned CNTW = (WORD_BITS > 1) ? $clog2(WORD_BITS) : 1;
  localparam logic [CNTW-1:0] LAST = CNTW'(WORD_BITS - 1);

  logic [CNTW-1:0] cnt_q, cnt_d;
  logic            active_q, active_d;
  logic            done_q, done_d;
  logic            cnt_en;

  assign take_bit = active_q & bit_valid & ~start;
  assign cnt_en   = start | take_bit;

  always_comb begin
    cnt_d    = cnt_q;
    active_d = active_q;
    done_d   = 1'b0;
    if (start) begin
      cnt_d    = '0;
      active_d = 1'b1;
    end else if (take_bit) begin
      if (cnt_q == LAST) begin
        cnt_d    = '0;
        active_d = 1'b0;
        done_d   = 1'b1;
      end else begin
        cnt_d = cnt_q + CNTW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q    <= cnt_d;
      active_q <= active_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= done_d;
  end

  assign done = done_q;
endmodule

// File: rtl/bsm_cand_array.sv
module bsm_cand_array #(
  parameter int unsigned NUM_STREAMS = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic                   take_bit,
  input  logic [NUM_STREAMS-1:0] stream_bits,
  output logic [NUM_STREAMS-1:0] cand
);
  logic [NUM_STREAMS-1:0] cand_q, cand_d;
  logic [NUM_STREAMS-1:0] hit;
  logic                   any_one;
  logic                   cand_en;

  for (genvar g = 0; g < NUM_STREAMS; g++) begin : g_hit
    assign hit[g] = cand_q[g] & stream_bits[g];
  end

  assign any_one = |hit;
  assign cand_en = start | take_bit;

  for (genvar g = 0; g < NUM_STREAMS; g++) begin : g_next
    always_comb begin
      if (start) cand_d[g] = 1'b1;
      else       cand_d[g] = cand_q[g] & (stream_bits[g] | ~any_one);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cand_q <= '0;
    else if (cand_en) cand_q <= cand_d;
  end

  assign cand = cand_q;
endmodule

// File: rtl/bsm_prio_enc.sv
module bsm_prio_enc #(
  parameter int unsigned NUM_STREAMS = 16,
  parameter int unsigned IDXW = $clog2(NUM_STREAMS)
) (
  input  logic [NUM_STREAMS-1:0] req,
  output logic [IDXW-1:0]        idx
);
  always_comb begin
    idx = '0;
    for (int i = NUM_STREAMS - 1; i >= 0; i--) begin
      if (req[i]) idx = IDXW'(i);
    end
  end
endmodule

// File: rtl/bitser_max_finder.sv
module bitser_max_finder
  import bsm_pkg::*;
#(
  parameter int unsigned NUM_STREAMS = DEF_STREAMS,
  parameter int unsigned WORD_BITS   = DEF_WORD_BITS,
  localparam int unsigned IDXW = (NUM_STREAMS > 1) ? $clog2(NUM_STREAMS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic                   bit_valid,
  input  logic [NUM_STREAMS-1:0] stream_bits,
  output logic [NUM_STREAMS-1:0] cand_flags,
  output logic [IDXW-1:0]        max_index,
  output logic                   done
);
  logic rst_sync_n;
  logic take_bit;

  bsm_reset_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  bsm_bit_counter #(.WORD_BITS(WORD_BITS)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .start     (start),
    .bit_valid (bit_valid),
    .take_bit  (take_bit),
    .done      (done)
  );

  bsm_cand_array #(.NUM_STREAMS(NUM_STREAMS)) u_cand (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .start       (start),
    .take_bit    (take_bit),
    .stream_bits (stream_bits),
    .cand        (cand_flags)
  );

  bsm_prio_enc #(.NUM_STREAMS(NUM_STREAMS), .IDXW(IDXW)) u_enc (
    .req (cand_flags),
    .idx (max_index)
  );
endmodule

// File: rtl/bsm_checker.sv
module bsm_checker #(
  parameter int unsigned NUM_STREAMS = 16,
  parameter int unsigned IDXW = 4
) (
  input logic                   clk,
  input logic                   rst_sync_n,
  input logic                   start,
  input logic                   bit_valid,
  input logic [NUM_STREAMS-1:0] cand_flags,
  input logic [IDXW-1:0]        max_index,
  input logic                   done
);
  logic [NUM_STREAMS-1:0] below_idx;
  assign below_idx = (NUM_STREAMS'(1) << max_index) - NUM_STREAMS'(1);

  a_r2_start_fills: assert property (@(posedge clk) disable iff (!rst_sync_n)
    start |=> (cand_flags == '1) && !done);

  a_r3_flags_only_fall: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !start |=> ((cand_flags & ~$past(cand_flags)) == '0));

  a_r3_never_empties: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!start && cand_flags != '0) |=> cand_flags != '0);

  a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!start && !bit_valid) |=> $stable(cand_flags));

  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done |=> !done);

  a_r7_lowest_index: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done |-> (cand_flags[max_index] && ((cand_flags & below_idx) == '0)));

  a_r8_hold_after_done: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (done && !start) |=> ($stable(cand_flags) && $stable(max_index)));
endmodule

bind bitser_max_finder bsm_checker #(.NUM_STREAMS(NUM_STREAMS), .IDXW(IDXW)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .start      (start),
  .bit_valid  (bit_valid),
  .cand_flags (cand_flags),
  .max_index  (max_index),
  .done       (done)
);

// File: tb/bitser_max_finder_tb.sv
module bitser_max_finder_tb;
  localparam int N = 16;
  localparam int M = 8;

  logic         clk;
  logic         rst_n;
  logic         start;
  logic         bit_valid;
  logic [N-1:0] stream_bits;
  logic [N-1:0] cand_flags;
  logic [3:0]   max_index;
  logic         done;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // each entry: {expected index, words packed with stream i at [8*i +: 8]}
  localparam logic [131:0] VECS [6] = '{
    {4'd9,  128'h10101010_10108010_10101010_10101010},
    {4'd3,  128'h7F7F7FFF_7F7F7F7F_7F7F7F7F_FF7F7F7F},
    {4'd0,  128'h00000000_00000000_00000000_00000000},
    {4'd0,  128'hFFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF},
    {4'd15, 128'hA5A4A4A4_A4A4A4A4_A4A4A4A4_A4A4A4A4},
    {4'd2,  128'h00000000_00000000_00000000_5A5B5A3C}
  };

  bitser_max_finder u_dut (
    .clk (clk), .rst_n (rst_n), .start (start), .bit_valid (bit_valid),
    .stream_bits (stream_bits), .cand_flags (cand_flags),
    .max_index (max_index), .done (done)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [N-1:0] max_mask(input logic [127:0] w);
    logic [7:0] mx = 8'h00;
    logic [N-1:0] m = '0;
    for (int i = 0; i < N; i++) if (w[8*i +: 8] > mx) mx = w[8*i +: 8];
    for (int i = 0; i < N; i++) m[i] = (w[8*i +: 8] == mx);
    return m;
  endfunction

  function automatic logic [N-1:0] slice(input logic [127:0] w, input int b);
    logic [N-1:0] s;
    for (int i = 0; i < N; i++) s[i] = w[8*i + b];
    return s;
  endfunction

  // inputs change on falling edges, outputs sampled 1 ns after rising edges
  task automatic tick;
    @(posedge clk); #1;
  endtask

  task automatic do_start;
    @(negedge clk); start = 1'b1; bit_valid = 1'b0;
    tick();
    chk(cand_flags == '1 && !done, "R2 start fills flags", 32'(cand_flags), 32'hFFFF);
    @(negedge clk); start = 1'b0;
  endtask

  task automatic send_bit(input logic [127:0] w, input int b);
    @(negedge clk); bit_valid = 1'b1; stream_bits = slice(w, b);
    tick();
    @(negedge clk); bit_valid = 1'b0;
  endtask

  task automatic run_word(input logic [127:0] w, input logic [3:0] exp_idx, input string tag);
    do_start();
    for (int b = M - 1; b >= 0; b--) begin
      @(negedge clk); bit_valid = 1'b1; stream_bits = slice(w, b);
      tick();
      if (b != 0) chk(!done, "R5 no early done", 32'(done), 0);
    end
    chk(done, {"R5 done after last bit ", tag}, 32'(done), 1);
    chk(cand_flags == max_mask(w), {"R6 survivors ", tag}, 32'(cand_flags), 32'(max_mask(w)));
    chk(max_index == exp_idx, {"R7 index ", tag}, 32'(max_index), 32'(exp_idx));
    @(negedge clk); bit_valid = 1'b0;
    tick();
    chk(!done, "R5 done lasts one cycle", 32'(done), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [127:0] w;
    logic [N-1:0] snap;
    logic [3:0]   isnap;
    rst_n = 1'b0; start = 1'b0; bit_valid = 1'b0; stream_bits = '0;
    repeat (3) @(posedge clk);
    #1;
    chk(cand_flags == '0 && !done && max_index == 0, "R1 in reset", 32'(cand_flags), 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) tick();
    // valid bits before any start must not matter
    @(negedge clk); bit_valid = 1'b1; stream_bits = '1;
    tick();
    @(negedge clk); bit_valid = 1'b0;
    chk(cand_flags == '0 && !done && max_index == 0, "R1 after release", 32'(cand_flags), 0);

    // table walk: R5 R6 R7
    foreach (VECS[k]) run_word(VECS[k][127:0], VECS[k][131:128], $sformatf("vec%0d", k));

    // R3 step-by-step narrowing
    w = VECS[5][127:0];
    do_start();
    send_bit(w, 7);
    chk(cand_flags == '1, "R3 all-zero bit keeps everyone", 32'(cand_flags), 32'hFFFF);
    send_bit(w, 6);
    chk(cand_flags == 16'h000E, "R3 zeros drop when a one exists", 32'(cand_flags), 32'h000E);

    // R4 gap with valid low and garbage bits
    snap = cand_flags;
    @(negedge clk); stream_bits = 16'h0001;
    repeat (3) tick();
    chk(cand_flags == snap, "R4 idle gap holds flags", 32'(cand_flags), 32'(snap));
    for (int b = 5; b >= 0; b--) send_bit(w, b);
    chk(cand_flags == 16'h0004 && max_index == 2, "R4 count held across gap", 32'(cand_flags), 32'h0004);

    // R8 ignore bits after done
    snap = cand_flags; isnap = max_index;
    for (int j = 0; j < 3; j++) begin
      @(negedge clk); bit_valid = 1'b1; stream_bits = 16'h0001 << j;
      tick();
      chk(!done, "R8 no further done", 32'(done), 0);
    end
    @(negedge clk); bit_valid = 1'b0;
    chk(cand_flags == snap && max_index == isnap, "R8 result held", 32'(cand_flags), 32'(snap));

    // R9 mid-word restart, with start and valid together
    w = VECS[0][127:0];
    do_start();
    for (int b = 7; b >= 4; b--) send_bit(w, b);
    @(negedge clk); start = 1'b1; bit_valid = 1'b1; stream_bits = 16'h0001;
    tick();
    chk(cand_flags == '1 && !done, "R9 start wins over valid", 32'(cand_flags), 32'hFFFF);
    @(negedge clk); start = 1'b0; bit_valid = 1'b0;
    w = VECS[4][127:0];
    for (int b = 7; b >= 1; b--) send_bit(w, b);
    chk(!done, "R9 restarted count not yet complete", 32'(done), 0);
    @(negedge clk); bit_valid = 1'b1; stream_bits = slice(w, 0);
    tick();
    chk(done && max_index == 15 && cand_flags == 16'h8000, "R9 full word after restart",
        32'(cand_flags), 32'h8000);
    @(negedge clk); bit_valid = 1'b0;

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule